// File: doc/BRIEF.md
# Programmable CCD Horizontal Clock Generator

This block produces the horizontal transfer clocks for a CCD sensor: eight H outputs plus a last-stage clock (HL) and a reset-gate clock (RG). It also produces two internal correlated-double-sampling strobes, one for the reset level (SHP) and one for the data level (SHD). A fine phase counter divides every pixel period into 64 positions. Each base waveform is set by a rising position, a falling position and a polarity bit.

A three-bit mode code selects how the eight H outputs are derived from one, two or three programmable base waveforms. Outputs are derived either as copies of a base waveform or as its inverse. Codes that are not one-hot are rejected: every H output is held low and an error flag is raised. Each output also has a three-bit drive code. This block reduces that code to an output-enable bit.

All settings arrive on plain input ports. They are sampled into a shadow copy only when the phase counter rolls over to zero, so a pixel period never mixes old and new settings. Every output is registered. An output shows the effect of phase position p in the cycle after the counter holds p.

Top module: `hclk_gen`

## Requirements
- R1: The phase counter holds 0 in the first cycle after reset. It then counts up by one each clock and wraps from 63 to 0. `pix_start` is high for exactly the one cycle that follows each counter value of 0.
- R2: Base channels are indexed as 0 = H1 base, 1 = H2 base, 2 = H5 base, 3 = HL and 4 = RG. Each channel's 6-bit positions sit at bits [6c+5:6c] of `rise_pos` and `fall_pos`. A channel's internal level goes to 1 when the counter equals its rising position. It goes to 0 when the counter equals its falling position. If the two positions are equal, the level holds its last value. The level is 0 after reset.
- R3: With polarity bit `pol[c]` = 1, a channel's output follows its level. With `pol[c]` = 0, the output is the level inverted. `hl_out` and `rg_out` carry channels 3 and 4.
- R4: Mode code 3'b001: H1, H3, H5 and H7 (`h_out` bits 0, 2, 4, 6) equal channel 0. H2, H4, H6 and H8 (bits 1, 3, 5, 7) are its inverse.
- R5: Mode code 3'b010: the even-indexed bits equal channel 0 and the odd-indexed bits equal channel 1.
- R6: Mode code 3'b100: bits 0 and 2 equal channel 0 and bits 1 and 3 are its inverse. Bits 4 and 6 equal channel 2 and bits 5 and 7 are its inverse.
- R7: Any other mode code drives all of `h_out` low and sets `mode_err`. HL and RG are unaffected.
- R8: `shp_out` and `shd_out` each pulse for one cycle in the cycle after the counter equals `shp_pos` or `shd_pos` respectively. Both may pulse in the same cycle.
- R9: `oe[k]` is 0 when the 3-bit drive code at `drv_code[3k+2:3k]` is 0, and 1 for any code from 1 to 7. Index k runs over H1..H8 (0..7), HL (8) and RG (9).
- R10: While reset is high, the settings are taken directly from the input ports. After that, a change on any setting input takes effect only from the cycle in which the counter next holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine phase clock |
| rst | input | 1 | Synchronous active-high reset |
| rise_pos | input | 30 | Rising positions, 6 bits per channel |
| fall_pos | input | 30 | Falling positions, 6 bits per channel |
| pol | input | 5 | Polarity per channel, 1 = pass through |
| shp_pos | input | 6 | Reset-level sample position |
| shd_pos | input | 6 | Data-level sample position |
| hmode | input | 3 | H output mapping code |
| drv_code | input | 30 | Drive codes, 3 bits per output |
| h_out | output | 8 | H1..H8 clocks, bit 0 = H1 |
| hl_out | output | 1 | Last-stage horizontal clock |
| rg_out | output | 1 | Reset-gate clock |
| shp_out | output | 1 | Reset-level sample strobe |
| shd_out | output | 1 | Data-level sample strobe |
| oe | output | 10 | Output enables derived from drive codes |
| mode_err | output | 1 | Mode code is not one of the three valid codes |
| pix_start | output | 1 | Pixel-period boundary marker |

## Verification
The risky coincidence is a settings update at the counter wrap that lands in the same cycle as an edge or strobe placed at position 0. The old settings govern position 63 and the new ones must govern position 0. To provoke it, the bench rewrites the mode, a rising position of 0 and both strobe positions of 0 in the middle of a pixel period. A cycle-level model that applies the update only at the wrap then judges every output in every cycle. The same run makes SHP and SHD fire in the same cycle, and moves a rising edge to 63 with a falling edge at 0, so that the wrap edge is exercised from both sides.

// File: rtl/hclk_pkg.sv
`timescale 1ns/1ps
package hclk_pkg;
  localparam logic [2:0] HM_COPY_INV = 3'b001;
  localparam logic [2:0] HM_TWO_BASE = 3'b010;
  localparam logic [2:0] HM_SPLIT    = 3'b100;

  localparam int NUM_CH  = 5;   // H1 base, H2 base, H5 base, HL, RG
  localparam int NUM_H   = 8;
  localparam int NUM_DRV = 10;  // H1..H8, HL, RG
  localparam int CH_A  = 0;
  localparam int CH_B  = 1;
  localparam int CH_C  = 2;
  localparam int CH_HL = 3;
  localparam int CH_RG = 4;

  function automatic logic hmode_ok(input logic [2:0] m);
    return (m == HM_COPY_INV) || (m == HM_TWO_BASE) || (m == HM_SPLIT);
  endfunction

  // bit 0 = H1 ... bit 7 = H8
  function automatic logic [NUM_H-1:0] hmap(input logic [2:0] m,
                                            input logic a, input logic b,
                                            input logic c);
    case (m)
      HM_COPY_INV: hmap = {~a, a, ~a, a, ~a, a, ~a, a};
      HM_TWO_BASE: hmap = { b, a,  b, a,  b, a,  b, a};
      HM_SPLIT:    hmap = {~c, c, ~c, c, ~a, a, ~a, a};
      default:     hmap = '0;
    endcase
  endfunction
endpackage

// File: rtl/hclk_phase_ctr.sv
`timescale 1ns/1ps
module hclk_phase_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] phase,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  assign last = &phase;
endmodule

// File: rtl/hclk_cfg_shadow.sv
`timescale 1ns/1ps
module hclk_cfg_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (load) q <= d;
  end
endmodule

// File: rtl/hclk_edge_wave.sv
`timescale 1ns/1ps
module hclk_edge_wave #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] phase,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic         wave_nxt,
  output logic         wave
);
  logic distinct;
  assign distinct = (rise != fall);

  always_comb begin
    wave_nxt = wave;
    if (distinct && phase == rise)      wave_nxt = 1'b1;
    else if (distinct && phase == fall) wave_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b0;
    else     wave <= wave_nxt;
  end
endmodule

// File: rtl/hclk_gen.sv
`timescale 1ns/1ps
module hclk_gen #(
  parameter int PHASE_W = 6,
  parameter int DRV_W   = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [hclk_pkg::NUM_CH*PHASE_W-1:0]   rise_pos,
  input  logic [hclk_pkg::NUM_CH*PHASE_W-1:0]   fall_pos,
  input  logic [hclk_pkg::NUM_CH-1:0]           pol,
  input  logic [PHASE_W-1:0]                    shp_pos,
  input  logic [PHASE_W-1:0]                    shd_pos,
  input  logic [2:0]                            hmode,
  input  logic [hclk_pkg::NUM_DRV*DRV_W-1:0]    drv_code,
  output logic [hclk_pkg::NUM_H-1:0]            h_out,
  output logic                                  hl_out,
  output logic                                  rg_out,
  output logic                                  shp_out,
  output logic                                  shd_out,
  output logic [hclk_pkg::NUM_DRV-1:0]          oe,
  output logic                                  mode_err,
  output logic                                  pix_start
);
  import hclk_pkg::*;

  localparam int POS_W = NUM_CH * PHASE_W;
  localparam int DRV_T = NUM_DRV * DRV_W;
  localparam int CFG_W = 2 * POS_W + NUM_CH + 2 * PHASE_W + 3 + DRV_T;

  logic [PHASE_W-1:0] phase;
  logic               last;
  logic [CFG_W-1:0]   cfg_in, cfg_act;

  hclk_phase_ctr #(.W(PHASE_W)) u_ctr (
    .clk(clk), .rst(rst), .phase(phase), .last(last)
  );

  // settings are copied at the wrap edge so position 0 already uses them
  assign cfg_in = {hmode, drv_code, shd_pos, shp_pos, pol, fall_pos, rise_pos};

  hclk_cfg_shadow #(.W(CFG_W)) u_shadow (
    .clk(clk), .load(rst | last), .d(cfg_in), .q(cfg_act)
  );

  logic [POS_W-1:0]   act_rise, act_fall;
  logic [NUM_CH-1:0]  act_pol;
  logic [PHASE_W-1:0] act_shp, act_shd;
  logic [DRV_T-1:0]   act_drv;
  logic [2:0]         act_mode;

  assign {act_mode, act_drv, act_shd, act_shp, act_pol, act_fall, act_rise} = cfg_act;

  logic [NUM_CH-1:0] wave_nxt, wave_q, shaped;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hclk_edge_wave #(.W(PHASE_W)) u_wave (
      .clk      (clk),
      .rst      (rst),
      .phase    (phase),
      .rise     (act_rise[c*PHASE_W +: PHASE_W]),
      .fall     (act_fall[c*PHASE_W +: PHASE_W]),
      .wave_nxt (wave_nxt[c]),
      .wave     (wave_q[c])
    );
    assign shaped[c] = act_pol[c] ? wave_nxt[c] : ~wave_nxt[c];
  end

  logic [NUM_DRV-1:0] oe_nxt;
  for (genvar k = 0; k < NUM_DRV; k++) begin : g_oe
    assign oe_nxt[k] = |act_drv[k*DRV_W +: DRV_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_out     <= '0;
      hl_out    <= 1'b0;
      rg_out    <= 1'b0;
      shp_out   <= 1'b0;
      shd_out   <= 1'b0;
      oe        <= '0;
      mode_err  <= 1'b0;
      pix_start <= 1'b0;
    end else begin
      h_out     <= hmap(act_mode, shaped[CH_A], shaped[CH_B], shaped[CH_C]);
      hl_out    <= shaped[CH_HL];
      rg_out    <= shaped[CH_RG];
      shp_out   <= (phase == act_shp);
      shd_out   <= (phase == act_shd);
      oe        <= oe_nxt;
      mode_err  <= ~hmode_ok(act_mode);
      pix_start <= (phase == '0);
    end
  end
endmodule

// File: rtl/hclk_gen_chk.sv
`timescale 1ns/1ps
module hclk_gen_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] phase,
  input logic [2:0]    act_mode,
  input logic [PW-1:0] act_shp,
  input logic [7:0]    h_out,
  input logic          mode_err,
  input logic          pix_start,
  input logic          shp_out
);
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    (phase != {PW{1'b1}}) |=> (phase == $past(phase) + 1'b1));

  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (phase == {PW{1'b1}}) |=> (phase == '0));

  a_r1_pix_marker: assert property (@(posedge clk) disable iff (rst)
    pix_start |-> (phase == PW'(1)));

  a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |-> $stable(act_mode));

  a_r7_h_low_on_err: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> (h_out == 8'h00));

  a_r4_copy_inverse: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(act_mode) == 3'b001) |->
      (h_out[2] == h_out[0] && h_out[4] == h_out[0] && h_out[6] == h_out[0] &&
       h_out[1] != h_out[0] && h_out[3] != h_out[0] && h_out[5] != h_out[0] &&
       h_out[7] != h_out[0]));

  a_r6_split_pairs: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(act_mode) == 3'b100) |->
      (h_out[2] == h_out[0] && h_out[1] != h_out[0] && h_out[3] != h_out[0] &&
       h_out[6] == h_out[4] && h_out[5] != h_out[4] && h_out[7] != h_out[4]));

  a_r8_strobe_position: assert property (@(posedge clk) disable iff (rst)
    shp_out |-> ($past(phase) == $past(act_shp)));
endmodule

bind hclk_gen hclk_gen_chk #(.PW(PHASE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase     (phase),
  .act_mode  (act_mode),
  .act_shp   (act_shp),
  .h_out     (h_out),
  .mode_err  (mode_err),
  .pix_start (pix_start),
  .shp_out   (shp_out)
);

// File: tb/hclk_gen_test.sv
`timescale 1ns/1ps
module hclk_gen_test;
  localparam int PW = 6;
  localparam int NC = 5;
  localparam int ND = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC*PW-1:0] rise_pos = '0;
  logic [NC*PW-1:0] fall_pos = '0;
  logic [NC-1:0]    pol = '1;
  logic [PW-1:0]    shp_pos = '0;
  logic [PW-1:0]    shd_pos = '0;
  logic [2:0]       hmode = 3'b001;
  logic [ND*3-1:0]  drv_code = '0;

  logic [7:0]  h_out;
  logic        hl_out, rg_out, shp_out, shd_out, mode_err, pix_start;
  logic [ND-1:0] oe;

  hclk_gen uut (
    .clk(clk), .rst(rst), .rise_pos(rise_pos), .fall_pos(fall_pos), .pol(pol),
    .shp_pos(shp_pos), .shd_pos(shd_pos), .hmode(hmode), .drv_code(drv_code),
    .h_out(h_out), .hl_out(hl_out), .rg_out(rg_out), .shp_out(shp_out),
    .shd_out(shd_out), .oe(oe), .mode_err(mode_err), .pix_start(pix_start)
  );

  always #2.5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int ph = 0;
  bit mw [NC];
  int m_rise [NC];
  int m_fall [NC];
  bit m_pol [NC];
  int m_shp, m_shd, m_mode;
  int m_drv [ND];
  bit [7:0] e_h = '0;
  bit e_hl = 0, e_rg = 0, e_shp = 0, e_shd = 0, e_err = 0, e_pix = 0;
  bit [ND-1:0] e_oe = '0;
  string e_tag = "R4";

  task automatic model_load();
    for (int c = 0; c < NC; c++) begin
      m_rise[c] = int'(rise_pos[c*PW +: PW]);
      m_fall[c] = int'(fall_pos[c*PW +: PW]);
      m_pol[c]  = pol[c];
    end
    m_shp = int'(shp_pos);
    m_shd = int'(shd_pos);
    m_mode = int'(hmode);
    for (int k = 0; k < ND; k++) m_drv[k] = int'(drv_code[k*3 +: 3]);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ph = 0;
      for (int c = 0; c < NC; c++) mw[c] = 0;
      model_load();
      e_h = '0; e_hl = 0; e_rg = 0; e_shp = 0; e_shd = 0;
      e_err = 0; e_pix = 0; e_oe = '0;
    end else begin
      bit sh [NC];
      for (int c = 0; c < NC; c++) begin
        if (m_rise[c] != m_fall[c] && ph == m_rise[c]) mw[c] = 1;
        else if (m_rise[c] != m_fall[c] && ph == m_fall[c]) mw[c] = 0;
        sh[c] = m_pol[c] ? mw[c] : !mw[c];
      end
      e_err = 0;
      for (int k = 0; k < 8; k++) begin
        case (m_mode)
          1: begin e_h[k] = (k % 2 == 1) ? !sh[0] : sh[0]; e_tag = "R4"; end
          2: begin e_h[k] = (k % 2 == 1) ? sh[1] : sh[0]; e_tag = "R5"; end
          4: begin
               if (k < 4) e_h[k] = (k % 2 == 1) ? !sh[0] : sh[0];
               else       e_h[k] = (k % 2 == 1) ? !sh[2] : sh[2];
               e_tag = "R6";
             end
          default: begin e_h[k] = 0; e_err = 1; e_tag = "R7"; end
        endcase
      end
      e_hl = sh[3];
      e_rg = sh[4];
      e_shp = (ph == m_shp);
      e_shd = (ph == m_shd);
      e_pix = (ph == 0);
      for (int k = 0; k < ND; k++) e_oe[k] = (m_drv[k] != 0);
      if (ph == 63) model_load();   // R10: new settings from position 0
      ph = (ph + 1) % 64;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(h_out == e_h, e_tag, "h_out", int'(h_out), int'(e_h));
      chk(mode_err == e_err, "R7", "mode_err", int'(mode_err), int'(e_err));
      chk(hl_out == e_hl, "R2 R3", "hl_out", int'(hl_out), int'(e_hl));
      chk(rg_out == e_rg, "R2 R3", "rg_out", int'(rg_out), int'(e_rg));
      chk(shp_out == e_shp, "R8", "shp_out", int'(shp_out), int'(e_shp));
      chk(shd_out == e_shd, "R8", "shd_out", int'(shd_out), int'(e_shd));
      chk(oe == e_oe, "R9", "oe", int'(oe), int'(e_oe));
      chk(pix_start == e_pix, "R1", "pix_start", int'(pix_start), int'(e_pix));
    end
  end

  task automatic set_edge(input int c, input int r, input int f);
    rise_pos[c*PW +: PW] = PW'(r);
    fall_pos[c*PW +: PW] = PW'(f);
  endtask

  task automatic set_drv(input int k, input int v);
    drv_code[k*3 +: 3] = 3'(v);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // initial settings, applied during reset (R10)
    set_edge(0, 4, 36); set_edge(1, 10, 50); set_edge(2, 20, 60);
    set_edge(3, 8, 40); set_edge(4, 2, 6);
    shp_pos = 6'd12; shd_pos = 6'd44; hmode = 3'b001;
    for (int k = 0; k < ND; k++) set_drv(k, (k % 4 == 0) ? 0 : k % 8); // R9 mix
    run(4);
    rst = 1'b0;
    // R1 R2 R4: copy/inverse mapping over full periods
    run(140);
    // R10: mid-period change to two-base mapping, deferred to wrap
    run(20);
    hmode = 3'b010; set_edge(1, 30, 5); set_drv(0, 4); set_drv(8, 7);
    run(150);
    // R6 with wrap edge: channel 0 rises at 63, falls at 0
    hmode = 3'b100; set_edge(0, 63, 0); set_edge(2, 20, 60);
    run(150);
    // R3: inverted polarity on H1 base and HL
    pol = 5'b10110;
    run(150);
    // R2: RG held by equal rise and fall positions
    pol = '1; set_edge(4, 5, 5);
    run(150);
    // R7: each rejected code
    hmode = 3'b000; run(70);
    hmode = 3'b011; run(70);
    hmode = 3'b111; run(70);
    hmode = 3'b110; run(70);
    hmode = 3'b101; run(70);
    // R8 R10: coincident update, edge at 0 and both strobes at 0
    run(37);
    hmode = 3'b001; set_edge(0, 0, 32); shp_pos = 6'd0; shd_pos = 6'd0;
    set_drv(3, 0); set_drv(9, 0);
    run(150);
    // R8: strobes on the last position
    shp_pos = 6'd63; shd_pos = 6'd63;
    run(140);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1;
    n_vec++;
    n_bad++;
    $display("FAIL R1 watchdog: actual 0 expected 1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule